// File: doc/BRIEF.md
# Vector Mask Logic Unit

This block executes the eight bitwise logical operations that combine two vector mask registers into a third. It accepts a 32-bit instruction word, a vector length, an encoded mask-element spacing and the grouping setting. It also takes both source masks and the current contents of the destination register. One cycle after a start pulse it presents the new destination value with a write enable, or it raises an illegal flag.

Each mask element sits at bit `i * mlen` of a VLEN-bit register. Elements below the vector length get the logical result. Elements from the vector length up to the last element that fits in the register are cleared. Bits between element positions keep their previous value. When the vector length is zero, nothing is written and the old destination value passes through unchanged.

Top module: `mask_logic_unit`

## Requirements
- R1: A start with `instrIn[6:0]=1010111`, `instrIn[14:12]=010` and a known funct6 in `instrIn[31:26]` gives `wrEnOut=1` when `vlIn>0`. If the opcode or funct3 differs, the result is `wrEnOut=0`, `illegalOut=0` and `vdOut` equal to `vdOldIn`.
- R2: funct6 selects the operation, with b taken from vs2 and a from vs1. The codes are 011001 b&a, 011101 ~(b&a), 011000 b&~a, 011011 b^a, 011010 b|a, 011110 ~(b|a), 011100 b|~a and 011111 ~(b^a).
- R3: Instruction bit 25 has no effect on the result.
- R4: Element i is read from and written to bit i*mlen, where mlen = 2^`mlenLog2In` and `mlenLog2In` runs from 0 to log2(VLEN).
- R5: Elements with index from vl up to VLEN/mlen-1 are written with zero.
- R6: During a write, destination bits that are not at a multiple of mlen keep their `vdOldIn` value.
- R7: When `vlIn=0`, the result is `wrEnOut=0` and `vdOut` equal to `vdOldIn`.
- R8: A matching opcode and funct3 with an unknown funct6 gives `illegalOut=1`, `wrEnOut=0` and `vdOut` equal to `vdOldIn`.
- R9: `validOut`, `wrEnOut`, `illegalOut`, `vdOut` and `lmulOut` update in the cycle after a start. `validOut` is high for exactly one cycle per start. After reset, all outputs are zero.
- R10: `lmulOut` carries the `lmulIn` value that was sampled with the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startIn | input | 1 | Start strobe for one operation |
| instrIn | input | 32 | Instruction word |
| vlIn | input | VL_W | Vector length, at most VLEN/mlen |
| mlenLog2In | input | MLOG_W | log2 of the element spacing |
| lmulIn | input | 3 | Grouping setting, passed through |
| vs1In | input | VLEN | Source mask a |
| vs2In | input | VLEN | Source mask b |
| vdOldIn | input | VLEN | Current destination contents |
| validOut | output | 1 | Result valid pulse |
| wrEnOut | output | 1 | Destination write enable |
| illegalOut | output | 1 | Unknown funct6 under a matching opcode |
| vdOut | output | VLEN | New destination value |
| lmulOut | output | 3 | Captured grouping setting |

## Verification
The hardest case to reach is the meeting of a coarse spacing, a short vector length and a preserved old value. Only then do non-element bits, tail elements and live elements all appear in one result. The stimulus pairs each operation with spacings of 1, 8 and VLEN and with vector lengths of 0, 1, mid-range and vlmax. It uses random sources and a random old value, so that cleared tail bits and kept gap bits differ from the old contents. Starts are also issued back to back, which checks that each result lines up with its own start.

// File: rtl/mlu_pkg.sv
package mlu_pkg;

  typedef enum logic [2:0] {
    OP_AND, OP_NAND, OP_ANDN, OP_XOR, OP_OR, OP_NOR, OP_ORN, OP_XNOR
  } mlu_op_e;

  typedef struct packed {
    logic    load;
    logic    doWrite;
    mlu_op_e op;
  } mlu_strobe_t;

  localparam logic [6:0] VEC_OPCODE = 7'b1010111;
  localparam logic [2:0] MASK_F3    = 3'b010;

  function automatic logic applyOp(mlu_op_e op, logic b, logic a);
    case (op)
      OP_AND:  return b & a;
      OP_NAND: return ~(b & a);
      OP_ANDN: return b & ~a;
      OP_XOR:  return b ^ a;
      OP_OR:   return b | a;
      OP_NOR:  return ~(b | a);
      OP_ORN:  return b | ~a;
      default: return ~(b ^ a);
    endcase
  endfunction

endpackage

// File: rtl/mlu_ctrl.sv
module mlu_ctrl
  import mlu_pkg::*;
#(
  parameter int VL_W = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            startIn,
  input  logic [31:0]     instrIn,
  input  logic [VL_W-1:0] vlIn,
  input  logic [2:0]      lmulIn,
  output mlu_strobe_t     strobeOut,
  output logic            validOut,
  output logic            wrEnOut,
  output logic            illegalOut,
  output logic [2:0]      lmulOut
);

  logic    isMaskGroup;
  logic    knownOp;
  mlu_op_e decodedOp;
  logic    doWrite;
  logic    flagIllegal;

  always_comb begin
    knownOp   = 1'b1;
    decodedOp = OP_AND;
    case (instrIn[31:26])
      6'b011001: decodedOp = OP_AND;
      6'b011101: decodedOp = OP_NAND;
      6'b011000: decodedOp = OP_ANDN;
      6'b011011: decodedOp = OP_XOR;
      6'b011010: decodedOp = OP_OR;
      6'b011110: decodedOp = OP_NOR;
      6'b011100: decodedOp = OP_ORN;
      6'b011111: decodedOp = OP_XNOR;
      default:   knownOp   = 1'b0;
    endcase
  end

  assign isMaskGroup = (instrIn[6:0] == VEC_OPCODE) && (instrIn[14:12] == MASK_F3);
  assign doWrite     = isMaskGroup && knownOp && (vlIn != '0);
  assign flagIllegal = isMaskGroup && !knownOp;

  always_comb begin
    strobeOut.load    = startIn;
    strobeOut.doWrite = doWrite;
    strobeOut.op      = decodedOp;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validOut   <= 1'b0;
      wrEnOut    <= 1'b0;
      illegalOut <= 1'b0;
      lmulOut    <= '0;
    end else begin
      validOut   <= startIn;
      wrEnOut    <= startIn && doWrite;
      illegalOut <= startIn && flagIllegal;
      if (startIn) lmulOut <= lmulIn;
    end
  end

  AST_VALID_AFTER_START: assert property (@(posedge clk) disable iff (!rstN)
    startIn |=> validOut); // R9
  AST_VALID_ONLY_AFTER_START: assert property (@(posedge clk) disable iff (!rstN)
    !startIn |=> !validOut); // R9
  AST_WRITE_IMPLIES_VALID: assert property (@(posedge clk) disable iff (!rstN)
    wrEnOut |-> validOut); // R9
  AST_ILLEGAL_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    illegalOut |-> !wrEnOut); // R8
  AST_ZERO_VL_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (startIn && vlIn == '0) |=> !wrEnOut); // R7

endmodule

// File: rtl/mlu_datapath.sv
module mlu_datapath
  import mlu_pkg::*;
#(
  parameter int VLEN   = 128,
  parameter int VL_W   = 8,
  parameter int MLOG_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  mlu_strobe_t       strobeIn,
  input  logic [VL_W-1:0]   vlIn,
  input  logic [MLOG_W-1:0] mlenLog2In,
  input  logic [VLEN-1:0]   vs1In,
  input  logic [VLEN-1:0]   vs2In,
  input  logic [VLEN-1:0]   vdOldIn,
  output logic [VLEN-1:0]   vdOut
);

  localparam int POS_W = $clog2(VLEN) + 1;

  logic [POS_W-1:0] gapMask;
  logic [VLEN-1:0]  nextVd;

  assign gapMask = (POS_W'(1) << mlenLog2In) - POS_W'(1);

  for (genvar j = 0; j < VLEN; j++) begin : gLane
    logic        onElem;
    logic [31:0] elemIdx;
    logic        inBody;
    logic        opBit;

    always_comb begin
      onElem  = ((POS_W'(j) & gapMask) == '0);
      elemIdx = 32'(j) >> mlenLog2In;
      inBody  = elemIdx < 32'(vlIn);
      opBit   = applyOp(strobeIn.op, vs2In[j], vs1In[j]);
      if (!strobeIn.doWrite || !onElem) nextVd[j] = vdOldIn[j];
      else if (inBody)                  nextVd[j] = opBit;
      else                              nextVd[j] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              vdOut <= '0;
    else if (strobeIn.load) vdOut <= nextVd;
  end

  AST_KEEP_WHEN_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (strobeIn.load && !strobeIn.doWrite) |=> vdOut == $past(vdOldIn)); // R7
  AST_GAP_BIT_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    (strobeIn.load && mlenLog2In != '0) |=> vdOut[1] == $past(vdOldIn[1])); // R6
  AST_HOLD_WITHOUT_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    !strobeIn.load |=> $stable(vdOut)); // R9

endmodule

// File: rtl/mask_logic_unit.sv
module mask_logic_unit
  import mlu_pkg::*;
#(
  parameter int VLEN   = 128,
  parameter int VL_W   = $clog2(VLEN + 1),
  parameter int MLOG_W = $clog2($clog2(VLEN) + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startIn,
  input  logic [31:0]       instrIn,
  input  logic [VL_W-1:0]   vlIn,
  input  logic [MLOG_W-1:0] mlenLog2In,
  input  logic [2:0]        lmulIn,
  input  logic [VLEN-1:0]   vs1In,
  input  logic [VLEN-1:0]   vs2In,
  input  logic [VLEN-1:0]   vdOldIn,
  output logic              validOut,
  output logic              wrEnOut,
  output logic              illegalOut,
  output logic [VLEN-1:0]   vdOut,
  output logic [2:0]        lmulOut
);

  mlu_strobe_t strobe;

  mlu_ctrl #(.VL_W(VL_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .startIn(startIn), .instrIn(instrIn),
    .vlIn(vlIn), .lmulIn(lmulIn), .strobeOut(strobe),
    .validOut(validOut), .wrEnOut(wrEnOut), .illegalOut(illegalOut),
    .lmulOut(lmulOut)
  );

  mlu_datapath #(.VLEN(VLEN), .VL_W(VL_W), .MLOG_W(MLOG_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobeIn(strobe), .vlIn(vlIn),
    .mlenLog2In(mlenLog2In), .vs1In(vs1In), .vs2In(vs2In),
    .vdOldIn(vdOldIn), .vdOut(vdOut)
  );

endmodule

// File: tb/mask_logic_unit_tb.sv
module mask_logic_unit_tb;

  localparam int CLK_PERIOD = 10;
  localparam int VLEN   = 128;
  localparam int VL_W   = $clog2(VLEN + 1);
  localparam int MLOG_W = $clog2($clog2(VLEN) + 1);

  typedef struct {
    logic            wr;
    logic            ill;
    logic [VLEN-1:0] vd;
    logic [2:0]      lmul;
    string           tag;
  } exp_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startIn = 1'b0;
  logic [31:0] instrIn = '0;
  logic [VL_W-1:0] vlIn = '0;
  logic [MLOG_W-1:0] mlenLog2In = '0;
  logic [2:0] lmulIn = '0;
  logic [VLEN-1:0] vs1In = '0, vs2In = '0, vdOldIn = '0;
  logic validOut, wrEnOut, illegalOut;
  logic [VLEN-1:0] vdOut;
  logic [2:0] lmulOut;

  int checks = 0;
  int errors = 0;
  exp_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  mask_logic_unit #(.VLEN(VLEN)) u_dut (
    .clk(clk), .rstN(rstN), .startIn(startIn), .instrIn(instrIn), .vlIn(vlIn),
    .mlenLog2In(mlenLog2In), .lmulIn(lmulIn), .vs1In(vs1In), .vs2In(vs2In),
    .vdOldIn(vdOldIn), .validOut(validOut), .wrEnOut(wrEnOut),
    .illegalOut(illegalOut), .vdOut(vdOut), .lmulOut(lmulOut)
  );

  function automatic logic [VLEN-1:0] rnd();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  function automatic logic [31:0] mkInstr(logic [5:0] f6, logic vm, logic [2:0] f3, logic [6:0] opc);
    return {f6, vm, 5'd3, 5'd2, f3, 5'd1, opc};
  endfunction

  // bit-serial reference from the requirement text
  function automatic exp_t model(logic [31:0] ins, int vl, int ml, logic [VLEN-1:0] a,
                                 logic [VLEN-1:0] b, logic [VLEN-1:0] old, logic [2:0] lm);
    exp_t e;
    logic match, known, r;
    int mlen, vlmax;
    e.vd = old; e.wr = 0; e.ill = 0; e.lmul = lm; e.tag = "";
    match = (ins[6:0] == 7'b1010111) && (ins[14:12] == 3'b010);
    known = 1'b1;
    case (ins[31:26])
      6'b011001, 6'b011101, 6'b011000, 6'b011011,
      6'b011010, 6'b011110, 6'b011100, 6'b011111: known = 1'b1;
      default: known = 1'b0;
    endcase
    e.ill = match && !known;
    if (match && known && vl != 0) begin
      e.wr = 1;
      mlen = 1 << ml;
      vlmax = VLEN / mlen;
      for (int i = 0; i < vlmax; i++) begin
        if (i < vl) begin
          case (ins[31:26])
            6'b011001: r = b[i*mlen] & a[i*mlen];
            6'b011101: r = ~(b[i*mlen] & a[i*mlen]);
            6'b011000: r = b[i*mlen] & ~a[i*mlen];
            6'b011011: r = b[i*mlen] ^ a[i*mlen];
            6'b011010: r = b[i*mlen] | a[i*mlen];
            6'b011110: r = ~(b[i*mlen] | a[i*mlen]);
            6'b011100: r = b[i*mlen] | ~a[i*mlen];
            default:   r = ~(b[i*mlen] ^ a[i*mlen]);
          endcase
          e.vd[i*mlen] = r;
        end else begin
          e.vd[i*mlen] = 1'b0;
        end
      end
    end
    return e;
  endfunction

  task automatic check(string tag, logic ok, string msg);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s", tag, msg);
    end
  endtask

  // driver: drive at negedge, push expectation
  task automatic issue(string tag, logic [31:0] ins, int vl, int ml,
                       logic [VLEN-1:0] a, logic [VLEN-1:0] b, logic [VLEN-1:0] old);
    exp_t e;
    logic [2:0] lm;
    @(negedge clk);
    lm = 3'($urandom);
    startIn = 1'b1; instrIn = ins; vlIn = VL_W'(vl); mlenLog2In = MLOG_W'(ml);
    lmulIn = lm; vs1In = a; vs2In = b; vdOldIn = old;
    e = model(ins, vl, ml, a, b, old, lm);
    e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      startIn = 1'b0;
    end
  endtask

  // monitor
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      if (rstN && validOut) begin
        if (sb.size() == 0) begin
          check("R9", 1'b0, "valid with no pending start");
        end else begin
          e = sb.pop_front();
          check(e.tag, wrEnOut == e.wr, $sformatf("wrEn act=%0b exp=%0b", wrEnOut, e.wr));
          check(e.tag, illegalOut == e.ill, $sformatf("illegal act=%0b exp=%0b", illegalOut, e.ill));
          check(e.tag, vdOut == e.vd, $sformatf("vd act=%h exp=%h", vdOut, e.vd));
          check("R10", lmulOut == e.lmul, $sformatf("lmul act=%0d exp=%0d", lmulOut, e.lmul));
        end
      end
    end
  end

  initial begin
    logic [5:0] ops[8];
    int mls[3];
    bit done;
    ops = '{6'b011001, 6'b011101, 6'b011000, 6'b011011,
            6'b011010, 6'b011110, 6'b011100, 6'b011111};
    mls = '{0, 3, 7};
    done = 0;
    fork
      begin
        repeat (3) @(negedge clk);
        rstN = 1'b1;
        @(negedge clk);
        check("R9", validOut == 0 && wrEnOut == 0 && illegalOut == 0 && vdOut == '0 && lmulOut == 0,
              $sformatf("reset act=%0b%0b%0b vd=%h exp=000 vd=0", validOut, wrEnOut, illegalOut, vdOut));
        // R2 R4 R5 R6: every op, several spacings and lengths
        foreach (ops[o]) begin
          foreach (mls[m]) begin
            int vmax;
            vmax = VLEN >> mls[m];
            issue("R2", mkInstr(ops[o], 1'b0, 3'b010, 7'b1010111), vmax, mls[m], rnd(), rnd(), rnd());
            issue("R5", mkInstr(ops[o], 1'b0, 3'b010, 7'b1010111), (vmax + 1) / 2, mls[m], rnd(), rnd(), rnd());
            issue("R4", mkInstr(ops[o], 1'b0, 3'b010, 7'b1010111), 1, mls[m], rnd(), rnd(), rnd());
          end
        end
        idle(2);
        // R6: gap bits kept with sparse elements
        issue("R6", mkInstr(6'b011010, 1'b0, 3'b010, 7'b1010111), 5, 2, '1, '1, '0);
        issue("R6", mkInstr(6'b011110, 1'b0, 3'b010, 7'b1010111), 16, 3, '0, '0, '1);
        // R7: vl zero
        issue("R7", mkInstr(6'b011111, 1'b0, 3'b010, 7'b1010111), 0, 0, rnd(), rnd(), rnd());
        issue("R7", mkInstr(6'b011001, 1'b0, 3'b010, 7'b1010111), 0, 3, rnd(), rnd(), rnd());
        // R3: vm bit set
        issue("R3", mkInstr(6'b011000, 1'b1, 3'b010, 7'b1010111), 77, 0, rnd(), rnd(), rnd());
        issue("R3", mkInstr(6'b011100, 1'b1, 3'b010, 7'b1010111), 9, 1, rnd(), rnd(), rnd());
        // R8: unknown funct6
        issue("R8", mkInstr(6'b010000, 1'b0, 3'b010, 7'b1010111), 20, 0, rnd(), rnd(), rnd());
        issue("R8", mkInstr(6'b011101 ^ 6'b100000, 1'b0, 3'b010, 7'b1010111), 20, 0, rnd(), rnd(), rnd());
        // R1: other funct3 / opcode
        issue("R1", mkInstr(6'b011001, 1'b0, 3'b001, 7'b1010111), 30, 0, rnd(), rnd(), rnd());
        issue("R1", mkInstr(6'b011001, 1'b0, 3'b010, 7'b0110011), 30, 0, rnd(), rnd(), rnd());
        idle(3);
        // R9: no valid without start, output held
        check("R9", validOut == 0, $sformatf("idle valid act=%0b exp=0", validOut));
        check("R9", sb.size() == 0, $sformatf("pending act=%0d exp=0", sb.size()));
        done = 1;
      end
      begin
        repeat (20000) @(negedge clk);
        if (!done) check("R9", 1'b0, "watchdog expired act=running exp=finished");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule